// File: doc/BRIEF.md
# Serial Flash Memory-Mapped Read Engine

This block lets a plain memory-style read port fetch words straight out of an external serial flash. A requester presents an address and a chip-select index; the engine drives that flash's select line low and sends a read opcode and address. It then idles through any dummy clocks, clocks in four data bytes and returns them as one 32-bit word with a one-cycle response strobe.

Every chip select owns a small setup word. The word holds the opcode to send, how many address bytes follow, how many dummy bytes come after them and how many data lanes the data phase uses. So one flash can be read with a plain single-lane command and another with a quad-lane fast read. A mode bit switches the serial port between this engine and register-driven command frames. While the mode bit is clear, or while such a frame is running, the engine refuses requests.

Top module: `flash_mmap_rd`

## Requirements
- R1: After reset all `cs_n` lines are high, `sclk` is low, `rsp_valid` is low and `req_ready` is low, because the mode bit resets to 0.
- R2: A configuration write to index NCS (4 by default) sets the mode bit from `cfg_wdata[0]`. While the mode bit is 0, `req_ready` stays low, and a held `req_valid` starts no transaction.
- R3: While `reg_busy` is high, `req_ready` is low and no transaction starts.
- R4: Each transaction begins with the 8-bit opcode from setup bits 7:0, sent most significant bit first on `io_out[0]` with `io_oe` = 4'b0001. Each bit is valid at the rising edge of `sclk`, and `sclk` stays high for one clock.
- R5: Setup bits 9:8 hold the address byte count minus one. That many low-order bytes of `req_addr` follow the opcode on `io_out[0]`, most significant bit first.
- R6: Setup bits 11:10 give a count of dummy bytes (0 to 3). Each dummy byte takes 8 `sclk` periods, and `io_oe` is 0 throughout the dummy and data phases.
- R7: Setup bits 13:12 choose the data lanes. Value 0 is single lane, with the bit read on `io_in[1]`. Value 1 is dual, with `io_in[1]` as the higher bit and `io_in[0]` as the lower. Value 3 is quad, with `io_in[3]` highest down to `io_in[0]`. The reserved value 2 behaves as single lane.
- R8: The data phase gathers 32 bits. Each byte arrives most significant bit first, and the first byte received lands in `rsp_data[7:0]`. `rsp_data` is valid during a one-cycle `rsp_valid` pulse.
- R9: Configuration indices 0 to NCS-1 write the setup word of that chip select. A request drives only `cs_n[req_cs]` low, and `sclk` is low whenever all `cs_n` are high.
- R10: The setup word is captured when a request is accepted. A write to that setup word during the transaction leaves the running transaction unchanged, and the next request uses the new value.
- R11: `req_ready` is low while a transaction is in progress. During the `rsp_valid` cycle all `cs_n` are already high and `req_ready` is low, so at least one deselected cycle separates two transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NCS+1) | 0..NCS-1 selects a setup word, NCS selects the mode bit |
| cfg_wdata | input | 14 | Setup word or mode bit (bit 0) |
| reg_busy | input | 1 | A register-driven frame owns the serial port |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_cs | input | $clog2(NCS) | Chip-select index of the request |
| req_addr | input | AW | Flash byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read word, first received byte in bits 7:0 |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | NCS | Active-low chip selects |
| io_out | output | 4 | Serial data out (only lane 0 carries data) |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Serial data in |

## Verification
A behavioural flash model decodes opcode, address and output-enable on every rising `sclk`. It then feeds a known word on exactly the lanes the setup word selects and drives the unused lanes with the complement. A wrong lane pick, a lane-order swap or a byte-order swap therefore corrupts the returned word. One chip select uses 1-byte addressing with the maximum dummy count and the reserved lane code, and another uses zero dummy bytes. A design that miscounts address or dummy clocks would shift the data by whole bytes, and one that treats lane code 2 as dual would read complemented lines. A setup write lands in the middle of a transaction: a design that reads the live word would change lane mode partway through. The bench also holds `req_valid` high while the mode bit is off or a register frame is busy, which catches a design that ignores either gate.

// File: rtl/flash_mmap_rd.sv
`timescale 1ns/1ps
module flash_mmap_rd #(
  parameter int NCS = 4,
  parameter int AW  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NCS+1)-1:0]   cfg_idx,
  input  logic [13:0]                cfg_wdata,
  input  logic                       reg_busy,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(NCS)-1:0]     req_cs,
  input  logic [AW-1:0]              req_addr,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_data,
  output logic                       sclk,
  output logic [NCS-1:0]             cs_n,
  output logic [3:0]                 io_out,
  output logic [3:0]                 io_oe,
  input  logic [3:0]                 io_in
);
  localparam int IW = $clog2(NCS+1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_DUM, S_RX, S_END} st_t;

  logic [13:0]    setup_q [NCS];
  logic           mm_en;
  st_t            st;
  logic           half;
  logic [39:0]    tx_sr;
  logic [31:0]    rx_sr;
  logic [5:0]     cnt;
  logic [5:0]     rx_last;
  logic [1:0]     ndum_q, lmode_q;
  logic [NCS-1:0] sel_q;
  logic [13:0]    sw;
  logic [31:0]    a32;
  logic           acc, active;

  for (genvar g = 0; g < NCS; g++) begin : g_setup
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) setup_q[g] <= '0;
      else if (cfg_we && cfg_idx == IW'(g)) setup_q[g] <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mm_en <= 1'b0;
    else if (cfg_we && cfg_idx == IW'(NCS)) mm_en <= cfg_wdata[0];

  assign sw        = setup_q[req_cs];
  assign a32       = 32'(req_addr);
  assign req_ready = (st == S_IDLE) && mm_en && !reg_busy;
  assign acc       = req_valid && req_ready;
  assign active    = (st == S_TX) || (st == S_DUM) || (st == S_RX);

  always_comb
    case (lmode_q)
      2'd3:    rx_last = 6'd7;
      2'd1:    rx_last = 6'd15;
      default: rx_last = 6'd31;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; half <= 1'b0; cnt <= '0; tx_sr <= '0; rx_sr <= '0;
      ndum_q <= '0; lmode_q <= '0; sel_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc) begin
          st      <= S_TX;
          half    <= 1'b0;
          tx_sr   <= {sw[7:0], a32 << {~sw[9:8], 3'b000}};
          cnt     <= 6'({sw[9:8], 3'b111}) + 6'd8;
          ndum_q  <= sw[11:10];
          lmode_q <= sw[13:12];
          sel_q   <= NCS'(1) << req_cs;
          rx_sr   <= '0;
        end
        S_TX: begin
          half <= ~half;
          if (half) begin
            tx_sr <= tx_sr << 1;
            if (cnt != 6'd0) cnt <= cnt - 6'd1;
            else if (ndum_q == 2'd0) begin st <= S_RX; cnt <= rx_last; end
            else begin st <= S_DUM; cnt <= 6'({ndum_q, 3'b000}) - 6'd1; end
          end
        end
        S_DUM: begin
          half <= ~half;
          if (half) begin
            if (cnt != 6'd0) cnt <= cnt - 6'd1;
            else begin st <= S_RX; cnt <= rx_last; end
          end
        end
        S_RX: begin
          half <= ~half;
          if (!half)
            case (lmode_q)
              2'd3:    rx_sr <= {rx_sr[27:0], io_in};
              2'd1:    rx_sr <= {rx_sr[29:0], io_in[1:0]};
              default: rx_sr <= {rx_sr[30:0], io_in[1]};
            endcase
          else if (cnt != 6'd0) cnt <= cnt - 6'd1;
          else st <= S_END;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign sclk      = half && active;
  assign cs_n      = active ? ~sel_q : '1;
  assign io_out    = {3'b000, (st == S_TX) && tx_sr[39]};
  assign io_oe     = {3'b000, st == S_TX};
  assign rsp_valid = (st == S_END);
  assign rsp_data  = {rx_sr[7:0], rx_sr[15:8], rx_sr[23:16], rx_sr[31:24]};

  AST_READY_MODE: assert property (@(posedge clk) disable iff (!rst_n) !mm_en |-> !req_ready); // R2
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) reg_busy |-> !req_ready); // R3
  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |=> $fell(sclk)); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R9
  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n) |-> !sclk); // R9
  AST_ACCEPT_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !(&cs_n) && !req_ready); // R11
endmodule

// File: tb/flash_mmap_rd_tb.sv
`timescale 1ns/1ps
module flash_mmap_rd_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_idx = '0; logic [13:0] cfg_wdata = '0;
  logic reg_busy = 1'b0, req_valid = 1'b0; logic [1:0] req_cs = '0; logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, sclk; logic [31:0] rsp_data;
  logic [3:0] cs_n, io_out, io_oe; logic [3:0] io_in = '0;
  wire cs_idle = &cs_n;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int sh_op [4], sh_ab [4], sh_dum [4], sh_lf [4];
  int m_ab = 1, m_dum = 0, m_lanes = 1; logic [31:0] m_word = '0;

  logic [31:0] exp_data_q [$], exp_addr_q [$]; logic [7:0] exp_op_q [$];
  logic [3:0] exp_csn_q [$]; string exp_tag_q [$];
  logic [31:0] cap_addr_q [$]; logic [7:0] cap_op_q [$]; logic [3:0] cap_csn_q [$]; bit cap_bad_q [$];

  always #4 clk = ~clk;

  flash_mmap_rd u_dut (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .reg_busy, .req_valid,
    .req_ready, .req_cs, .req_addr, .rsp_valid, .rsp_data, .sclk, .cs_n, .io_out, .io_oe, .io_in);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanes_of(input int lf);
    return (lf == 3) ? 4 : (lf == 1) ? 2 : 1;
  endfunction

  task automatic cfg_write(input int idx, input logic [13:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_setup(input int cs, input int op, input int ab, input int dum, input int lf);
    sh_op[cs] = op; sh_ab[cs] = ab; sh_dum[cs] = dum; sh_lf[cs] = lf;
    cfg_write(cs, {2'(lf), 2'(dum), 2'(ab - 1), 8'(op)});
  endtask

  task automatic do_read(input int cs, input logic [31:0] addr, input logic [31:0] word, input string tag);
    logic [31:0] mask;
    mask = (sh_ab[cs] == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * sh_ab[cs])) - 32'h1);
    m_ab = sh_ab[cs]; m_dum = sh_dum[cs]; m_lanes = lanes_of(sh_lf[cs]); m_word = word;
    exp_data_q.push_back(word); exp_op_q.push_back(8'(sh_op[cs]));
    exp_addr_q.push_back(addr & mask); exp_csn_q.push_back(~(4'b0001 << cs)); exp_tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cs = 2'(cs); req_addr = addr;
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  // flash model
  initial begin
    int n, ca, d, k, ln; logic [7:0] op; logic [31:0] ad, strm; logic [3:0] csn; bit bad;
    logic b; logic [1:0] two;
    forever begin
      @(negedge cs_idle);
      n = 0; op = '0; ad = '0; bad = 1'b0; csn = cs_n;
      ca = 8 * (1 + m_ab); d = ca + 8 * m_dum; ln = m_lanes;
      strm = {m_word[7:0], m_word[15:8], m_word[23:16], m_word[31:24]};
      forever begin
        @(posedge sclk or posedge cs_idle);
        if (cs_idle) break;
        if (n < ca) begin
          if (io_oe != 4'b0001) bad = 1'b1;
          if (n < 8) op = {op[6:0], io_out[0]};
          else ad = {ad[30:0], io_out[0]};
        end else if (io_oe != 4'b0000) bad = 1'b1;
        n++;
        @(negedge sclk or posedge cs_idle);
        if (cs_idle) break;
        if (n >= d) begin
          k = n - d;
          if (k < 32 / ln) begin
            if (ln == 4) io_in = strm[31 - 4*k -: 4];
            else if (ln == 2) begin two = strm[31 - 2*k -: 2]; io_in = {~two, two}; end
            else begin b = strm[31 - k]; io_in = {~b, ~b, b, ~b}; end
          end
        end
      end
      cap_op_q.push_back(op); cap_addr_q.push_back(ad); cap_csn_q.push_back(csn); cap_bad_q.push_back(bad);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data_q.size() == 0 || cap_op_q.size() == 0) begin
        chk(1'b0, "R8 unexpected response", rsp_data, 32'h0);
      end else begin
        string tag;
        tag = exp_tag_q.pop_front();
        chk(rsp_data == exp_data_q[0], {tag, " data R8"}, rsp_data, exp_data_q[0]);
        chk(cap_op_q[0] == exp_op_q[0], {tag, " opcode R4"}, 32'(cap_op_q[0]), 32'(exp_op_q[0]));
        chk(cap_addr_q[0] == exp_addr_q[0], {tag, " address R5"}, cap_addr_q[0], exp_addr_q[0]);
        chk(cap_csn_q[0] == exp_csn_q[0], {tag, " select R9"}, 32'(cap_csn_q[0]), 32'(exp_csn_q[0]));
        chk(!cap_bad_q[0], {tag, " output enable R6"}, 32'(cap_bad_q[0]), 32'h0);
        chk(cs_idle && !req_ready, {tag, " released R11"}, {cs_n, 3'b0, req_ready}, 32'h0000_00F0 >> 4 << 4 | 32'hF0);
        void'(exp_data_q.pop_front()); void'(exp_op_q.pop_front()); void'(exp_addr_q.pop_front());
        void'(exp_csn_q.pop_front()); void'(cap_op_q.pop_front()); void'(cap_addr_q.pop_front());
        void'(cap_csn_q.pop_front()); void'(cap_bad_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hold_valid_idle(input string req);
    bit stayed;
    stayed = 1'b1;
    req_valid = 1'b1; req_cs = 2'd1; req_addr = 32'h10;
    repeat (12) begin @(negedge clk); if (!cs_idle || req_ready) stayed = 1'b0; end
    req_valid = 1'b0;
    chk(stayed, req, 32'(stayed), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 32'h0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk(req_ready == 1'b0, "R1 req_ready", 32'(req_ready), 32'h0);

    set_setup(0, 8'h03, 3, 0, 0);
    set_setup(1, 8'h3B, 4, 1, 1);
    set_setup(2, 8'h6B, 3, 1, 3);
    set_setup(3, 8'h0B, 1, 3, 2);

    hold_valid_idle("R2 mode off refuses");
    cfg_write(4, 14'h1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 mode on ready", 32'(req_ready), 32'h1);

    reg_busy = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 busy ready", 32'(req_ready), 32'h0);
    hold_valid_idle("R3 busy refuses");
    reg_busy = 1'b0;

    do_read(0, 32'h0012_3456, 32'hA1B2_C3D4, "R7 single");
    do_read(0, 32'hFF00_0001, 32'h8001_7FFE, "R7 single");
    do_read(1, 32'h89AB_CDEF, 32'h0F1E_2D3C, "R7 dual");
    do_read(1, 32'h0000_0000, 32'hFFFF_0000, "R7 dual");
    do_read(2, 32'h00FE_DCBA, 32'h55AA_33CC, "R7 quad");
    do_read(2, 32'h1234_5678, 32'h1357_9BDF, "R7 quad");
    do_read(3, 32'h0000_00C3, 32'hDEAD_BEEF, "R7 reserved lanes R6 max dummy");
    do_read(3, 32'hABCD_EF5A, 32'h0102_0408, "R5 one address byte");

    // R10: rewrite setup of cs0 mid-transaction
    fork
      do_read(0, 32'h0000_4242, 32'hC0FF_EE11, "R10 old setup");
      begin
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b0, "R11 busy mid transaction", 32'(req_ready), 32'h0);
        chk(cs_n == 4'hE, "R9 select held", 32'(cs_n), 32'hE);
        sh_op[0] = 8'hEB; sh_ab[0] = 4; sh_dum[0] = 2; sh_lf[0] = 1;
        cfg_idx = 3'd0; cfg_wdata = {2'd1, 2'd2, 2'd3, 8'hEB}; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
      end
    join
    do_read(0, 32'h7654_3210, 32'h2468_ACE0, "R10 new setup");
    do_read(2, 32'h0000_0100, 32'h9876_5432, "R9 other select");

    cfg_write(4, 14'h0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 mode cleared", 32'(req_ready), 32'h0);
    hold_valid_idle("R2 mode cleared refuses");
    repeat (5) @(negedge clk);
    chk(exp_data_q.size() == 0, "R8 all responses seen", 32'(exp_data_q.size()), 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule